// File: doc/BRIEF.md
# UART Line Status and Receive-Error Tracker

This block sits beside a UART receive path and keeps the eight-bit line status word that a host polls. A deserializer hands it finished characters, each marked with parity-error, framing-error and break flags. The block stores them in a receive buffer whose entries keep their own error marks. It reports data-ready, overrun and the per-character errors, and it also reports the state of the transmit holding register and the transmit shift register. A receiver-line-status interrupt request is raised from the error bits when it is enabled.

In character mode the buffer holds a single character, and a new arrival replaces an unread one. In FIFO mode the buffer holds `DEPTH` characters. A character's error marks reach the status word only when that character is at the head, and an arrival into a full buffer is discarded. After a break in FIFO mode, one zero character is stored and loading stops until the line has gone back to mark and a valid start bit has been seen. The host side consists of strobes: read receive buffer (pops the head), read status (clears the error bits) and write holding register.

Top module: `uart_lsr_tracker`

## Requirements
- R1: After reset the buffer is empty, all error bits are 0, the holding register counts as empty and `irq` is 0. With `tsr_empty`=1 the status word `lsr` reads 8'h60. Its bit order from bit 7 down to bit 0 is: FIFO-error summary, transmitter empty, holding empty, break, framing, parity, overrun, data ready.
- R2: `lsr[0]` is 1 whenever the buffer holds at least one character. It returns to 0 after a receive-buffer read removes the last one.
- R3: In FIFO mode up to `DEPTH` (16) characters are kept. `rbr_data` shows the oldest one, and each `rbr_rd` pulse removes it, so characters come out in arrival order.
- R4: In FIFO mode, a character that completes while the buffer is full (with no read in the same cycle) sets `lsr[1]` in the same clock edge. That character is dropped and the stored characters are unchanged.
- R5: In character mode the buffer holds one character. A new character that arrives before the old one is read replaces it and sets `lsr[1]`.
- R6: The parity, framing and break marks of a character (`lsr[2]`, `lsr[3]`, `lsr[4]`) are set one clock after that character becomes the head. Marks on characters further back in the buffer do not show.
- R7: A `lsr_rd` pulse clears `lsr[4:1]`. If a mark becomes visible, or an overrun happens, in the same cycle as the read, that bit is left at 1.
- R8: `lsr[7]` reads 0 in character mode. In FIFO mode it is set when a character with any error mark is stored, and it is cleared by `lsr_rd` unless another such character is stored in that same cycle.
- R9: In FIFO mode, a character flagged as a break is stored as 8'h00 with its break mark, and later characters are dropped without an overrun. Loading resumes after `rx_mark` has been seen and a later `rx_start` arrives; an `rx_start` with no `rx_mark` before it does not resume loading.
- R10: `thr_wr` clears `lsr[5]` and `lsr[6]`. `thr_load` sets `lsr[5]` again. `lsr[6]` equals `lsr[5]` AND `tsr_empty`.
- R11: `irq` is `rls_en` AND (`lsr[4]` OR `lsr[3]` OR `lsr[2]` OR `lsr[1]`).
- R12: Changing `fifo_mode` empties the buffer, clears `lsr[7]` and ends any break blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = character mode |
| rx_valid | input | 1 | A received character is complete this cycle |
| rx_data | input | DW | Received character |
| rx_perr | input | 1 | Parity error on this character |
| rx_ferr | input | 1 | Stop bit sampled as 0 |
| rx_brk | input | 1 | Line held at 0 longer than one character time |
| rx_mark | input | 1 | Serial line is at mark (1) |
| rx_start | input | 1 | A valid start bit was detected |
| rbr_rd | input | 1 | Host reads the receive buffer (pop) |
| lsr_rd | input | 1 | Host reads the status word |
| thr_wr | input | 1 | Host writes the transmit holding register |
| thr_load | input | 1 | Transmitter moved the holding register into its shift register |
| tsr_empty | input | 1 | Transmit shift register is empty |
| rls_en | input | 1 | Line-status interrupt enable |
| rbr_data | output | DW | Head character (0 when empty) |
| lsr | output | 8 | Line status word |
| irq | output | 1 | Line-status interrupt request |

## Verification
The hardest cases to reach are a status read that lands in the same cycle as an error mark surfacing, and a mark on an entry deep in a full buffer. The bench reaches the first by pushing a parity-flagged character into an empty buffer and putting `lsr_rd` in the very next cycle, the one in which the mark is latched. It reaches the second by filling all 16 entries with only the fourth one flagged. It then checks that the framing bit stays 0 through an overrun and a status read, and that it goes to 1 one clock after the third pop. The break lock-out is driven through a stray start bit with no mark before it, then a proper mark-then-start.

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          rx_mark,
  input  logic          rx_start,
  input  logic          rbr_rd,
  input  logic          lsr_rd,
  input  logic          thr_wr,
  input  logic          thr_load,
  input  logic          tsr_empty,
  input  logic          rls_en,
  output logic [DW-1:0] rbr_data,
  output logic [7:0]    lsr,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem_d [DEPTH];
  logic [2:0]    mem_t [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt, cap;
  logic mode_q, blk, mark_seen, pend, thre, ffe, bi, fe, pe, oe;
  logic flush, take, pop, room, push, ovw, ovr, head_chg;
  logic [DW-1:0] in_d;
  logic [2:0]    in_t;

  assign flush    = fifo_mode != mode_q;
  assign cap      = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign take     = rx_valid && !flush && !(fifo_mode && blk);
  assign pop      = rbr_rd && (cnt != '0) && !flush;
  assign room     = (cnt < cap) || pop;
  assign push     = take && room;
  assign ovr      = take && !room;
  assign ovw      = ovr && !fifo_mode;
  assign in_d     = rx_brk ? '0 : rx_data;
  assign in_t     = {rx_brk, rx_ferr, rx_perr};
  assign cnt_nxt  = cnt + CW'(push) - CW'(pop);
  assign head_chg = (pop && cnt_nxt != '0) || (push && cnt == '0) || ovw;

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wp] <= in_d;
      mem_t[wp] <= in_t;
    end else if (ovw) begin
      mem_d[rp] <= in_d;
      mem_t[rp] <= in_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
    end else begin
      mode_q <= fifo_mode;
      pend   <= head_chg;
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= wp + AW'(1);
        if (pop)  rp <= rp + AW'(1);
        cnt <= cnt_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bi  <= 1'b0;
      fe  <= 1'b0;
      pe  <= 1'b0;
      oe  <= 1'b0;
      ffe <= 1'b0;
    end else begin
      bi  <= (bi & !lsr_rd) | (pend & !flush & mem_t[rp][2]);
      fe  <= (fe & !lsr_rd) | (pend & !flush & mem_t[rp][1]);
      pe  <= (pe & !lsr_rd) | (pend & !flush & mem_t[rp][0]);
      oe  <= (oe & !lsr_rd) | ovr;
      ffe <= flush ? 1'b0 : ((ffe & !lsr_rd) | (push & fifo_mode & (|in_t)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk       <= 1'b0;
      mark_seen <= 1'b0;
    end else if (flush) begin
      blk       <= 1'b0;
      mark_seen <= 1'b0;
    end else if (fifo_mode && rx_valid && rx_brk && !blk) begin
      blk       <= 1'b1;
      mark_seen <= 1'b0;
    end else if (blk) begin
      if (mark_seen && rx_start) begin
        blk       <= 1'b0;
        mark_seen <= 1'b0;
      end else if (rx_mark) begin
        mark_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thre <= 1'b1;
    else if (thr_wr)   thre <= 1'b0;
    else if (thr_load) thre <= 1'b1;
  end

  assign rbr_data = (cnt != '0) ? mem_d[rp] : '0;
  assign lsr      = {fifo_mode & ffe, thre & tsr_empty, thre, bi, fe, pe, oe, cnt != '0};
  assign irq      = rls_en & (bi | fe | pe | oe);
endmodule

// File: rtl/uart_lsr_tracker_chk.sv
module uart_lsr_tracker_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_mode,
  input logic                       rx_valid,
  input logic                       rbr_rd,
  input logic                       lsr_rd,
  input logic                       thr_wr,
  input logic                       rls_en,
  input logic [7:0]                 lsr,
  input logic                       irq,
  input logic [$clog2(DEPTH):0]     cnt,
  input logic                       pend,
  input logic                       ovr,
  input logic                       blk,
  input logic                       flush
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_single_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !flush) |-> cnt <= CW'(1));

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !flush && !blk && rx_valid && !rbr_rd && cnt == CW'(DEPTH))
    |=> (lsr[1] && cnt == CW'(DEPTH)));

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !pend && !ovr) |=> lsr[4:1] == 4'b0000);

  p_thr_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (!lsr[5] && !lsr[6]));

  p_break_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !flush && blk && rx_valid && !rbr_rd) |=> $stable(cnt));

  p_char_bit7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !lsr[7]);

  p_dr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !rx_valid && !flush && cnt == CW'(1)) |=> !lsr[0]);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rls_en |-> !irq);
endmodule

bind uart_lsr_tracker uart_lsr_tracker_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_lsr_tracker_tb.sv
module uart_lsr_tracker_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 1'b0, rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic rx_mark = 1'b0, rx_start = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic thr_wr = 1'b0, thr_load = 1'b0, tsr_empty = 1'b1, rls_en = 1'b1;
  logic [7:0] rx_data = '0;
  logic [7:0] rbr_data, lsr;
  logic irq;

  int total = 0, bad = 0;
  logic [7:0] q[$];

  always #(PERIOD/2) clk = ~clk;

  uart_lsr_tracker u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: compares each popped character against the scoreboard
  always @(posedge clk) begin
    if (rst_n && rbr_rd && q.size() != 0) begin
      logic [7:0] e;
      e = q.pop_front();
      chk("R3 head data order", rbr_data, e);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // act: 0 dropped, 1 stored, 2 replaces the stored one
  task automatic send(input logic [7:0] d, input logic p, input logic f, input logic b, input int act);
    @(negedge clk);
    rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b; rx_valid = 1'b1;
    if (act == 1) q.push_back(b ? 8'h00 : d);
    else if (act == 2) begin
      void'(q.pop_back());
      q.push_back(b ? 8'h00 : d);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: rbr_rd = 1'b1;
      1: lsr_rd = 1'b1;
      2: thr_wr = 1'b1;
      3: thr_load = 1'b1;
      4: rx_mark = 1'b1;
      default: rx_start = 1'b1;
    endcase
    @(negedge clk);
    rbr_rd = 1'b0; lsr_rd = 1'b0; thr_wr = 1'b0; thr_load = 1'b0; rx_mark = 1'b0; rx_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    finish_run();
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step();
    chk("R1 reset status word", lsr, 8'h60);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);

    // character mode
    send(8'hA5, 0, 0, 0, 1);
    step();
    chk("R2 data ready set", lsr, 8'h61);
    strobe(0);
    chk("R2 data ready cleared", {7'b0, lsr[0]}, 8'h00);

    send(8'h11, 0, 0, 0, 1);
    send(8'h22, 0, 0, 0, 2);
    chk("R5 char-mode overrun", {7'b0, lsr[1]}, 8'h01);
    chk("R11 irq on overrun", {7'b0, irq}, 8'h01);
    rls_en = 1'b0;
    step();
    chk("R11 irq gated off", {7'b0, irq}, 8'h00);
    rls_en = 1'b1;
    strobe(1);
    chk("R7 status read clears errors", {4'b0, lsr[4:1]}, 8'h00);
    chk("R7 irq drops after read", {7'b0, irq}, 8'h00);
    strobe(0);

    send(8'h33, 1, 0, 0, 1);
    step();
    chk("R6 parity visible at head", {7'b0, lsr[2]}, 8'h01);
    chk("R8 bit7 zero in char mode", {7'b0, lsr[7]}, 8'h00);
    strobe(1);

    // mode change with a character still held
    @(negedge clk);
    fifo_mode = 1'b1;
    q.delete();
    step();
    chk("R12 mode change empties buffer", {7'b0, lsr[0]}, 8'h00);

    // fill the FIFO, entry 3 carries a framing error
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 3), 0, (i == 3), 0, 1);
    step();
    chk("R6 framing hidden until head", {7'b0, lsr[3]}, 8'h00);
    chk("R8 bit7 set by stored error", {7'b0, lsr[7]}, 8'h01);
    send(8'hEE, 0, 0, 0, 0);
    chk("R4 overrun on full FIFO", {7'b0, lsr[1]}, 8'h01);
    strobe(1);
    chk("R8 bit7 cleared by read", {7'b0, lsr[7]}, 8'h00);
    chk("R7 overrun cleared by read", {7'b0, lsr[1]}, 8'h00);
    for (int i = 0; i < 3; i++) strobe(0);
    step();
    chk("R6 framing shows at head", {7'b0, lsr[3]}, 8'h01);
    for (int i = 0; i < 13; i++) strobe(0);
    step();
    chk("R2 empty after full drain", {7'b0, lsr[0]}, 8'h00);
    chk("R4 dropped char never read", 8'(q.size()), 8'h00);
    strobe(1);

    // read in the same cycle the parity mark surfaces
    @(negedge clk);
    rx_data = 8'h5C; rx_perr = 1'b1; rx_valid = 1'b1;
    q.push_back(8'h5C);
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
    chk("R7 mark kept on colliding read", {7'b0, lsr[2]}, 8'h01);
    strobe(1);
    chk("R7 next read clears parity", {7'b0, lsr[2]}, 8'h00);
    strobe(0);

    // break lock-out
    send(8'hFF, 0, 0, 1, 1);
    send(8'h44, 0, 0, 0, 0);
    strobe(5);
    send(8'h45, 0, 0, 0, 0);
    strobe(4);
    strobe(5);
    send(8'h46, 0, 0, 0, 1);
    step();
    chk("R9 break mark at head", {7'b0, lsr[4]}, 8'h01);
    chk("R9 no overrun while blocked", {7'b0, lsr[1]}, 8'h00);
    strobe(0);
    strobe(0);
    step();
    chk("R9 only two stored", {7'b0, lsr[0]}, 8'h00);
    chk("R9 scoreboard drained", 8'(q.size()), 8'h00);
    strobe(1);

    // transmitter flags
    chk("R10 idle flags", {6'b0, lsr[6:5]}, 8'h03);
    strobe(2);
    chk("R10 write clears both", {6'b0, lsr[6:5]}, 8'h00);
    tsr_empty = 1'b0;
    strobe(3);
    chk("R10 load sets holding empty", {6'b0, lsr[6:5]}, 8'h01);
    tsr_empty = 1'b1;
    step();
    chk("R10 shift empty sets temt", {6'b0, lsr[6:5]}, 8'h03);

    finish_run();
  end
endmodule